// File: doc/BRIEF.md
# Fixed-Threshold Frame Synchronizer

This block takes a recovered serial bit stream, one data bit per clock enable, and finds a fixed sync code in it. Each accepted bit enters a history of up to 32 bits. The newest K bits are compared against a programmable sync pattern, and the number of mismatching bits is counted. In search mode every bit position is tested against a strict mismatch limit. Once the code is found, a bits-per-frame counter opens a one-bit window exactly one frame later. From then on the code is tested only at that window, against a looser mismatch limit. An optional verification count makes the block wait for several consecutive hits before it locks, and for several consecutive misses before it drops lock.

Outputs are two mode levels (locked, searching) and three single-cycle pulses: one per frame held in lock, one when a lock is lost, and one when search is re-entered. External counters can total these pulses to measure bit-slip rate and acquisition time.

Top module: `frame_sync_tracker`

## Requirements
- R1: While reset is asserted and after it is released, the lock level is 0, the search level is 1, and all pulses are 0; the bit history starts as all zeros.
- R2: In search mode with no pending candidate, every enabled bit is a test position. The received bits are compared with the pattern, most significant pattern bit received first, so the bit just received matches pattern bit 0. The position is a hit when at most the search mismatch limit of bits differ.
- R3: In lock mode, the window bit is a hit when at most the lock mismatch limit of bits differ; a window with more errors than the search limit but no more than the lock limit keeps lock.
- R4: With a verification count of 0, lock is entered on the first hit and left on the first window miss.
- R5: With a verification count V greater than 0, lock needs V+1 consecutive hits spaced exactly one frame apart, and lock is left only after V+1 consecutive window misses. A hit resets the miss run, and a window miss while still searching drops the candidate.
- R6: The sync window is one bit wide and falls exactly frame-length enabled bits after the previous sync end; in lock, a copy of the pattern at any other position has no effect.
- R7: Each lock-mode window that does not end lock gives exactly one one-cycle frame-in-lock pulse, in the cycle after that bit's enable; the window that enters lock gives none.
- R8: On loss of lock, a miss pulse and a search pulse are raised together for one cycle, in the same cycle that the lock level falls.
- R9: Cycles with the bit enable low change neither the bit history nor the frame position, and produce no pulse.
- R10: The pattern, pattern length, frame length, both mismatch limits and the verification count are captured at the first clock after reset; later changes on those inputs are ignored until the next reset.
- R11: Pattern bits at or above the pattern length K take no part in the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Qualifies bit_i as a new stream bit |
| bit_i | input | 1 | Serial data bit |
| pattern_i | input | MAX_K (32) | Sync pattern; bit K-1 is sent first |
| pat_len_i | input | ERR_W (6) | Pattern length K, 8 to MAX_K |
| frame_len_i | input | CNT_W (12) | Frame length in bits, K to MAX_FRAME |
| search_tol_i | input | ERR_W (6) | Mismatch limit in search mode |
| lock_tol_i | input | ERR_W (6) | Mismatch limit in lock mode |
| verify_i | input | VER_W (3) | Number of extra consecutive hits or misses required |
| lock_o | output | 1 | Lock level |
| search_o | output | 1 | Search level |
| search_pulse_o | output | 1 | One-cycle pulse when search is re-entered |
| frame_ok_o | output | 1 | One-cycle pulse per frame held in lock |
| miss_o | output | 1 | One-cycle pulse when lock is lost |

## Verification
The bench targets the mismatch-limit boundaries: a sync code with exactly the lock limit of errors must keep lock, and one more error must drop it. A design that picked the wrong limit for the mode would lose lock early or never lose it. Verification runs are driven with a single good hit followed by a corrupted frame, and with alternating misses and hits. A design that did not clear its run counter would lock on scattered hits or drop lock on non-consecutive misses. A pattern copy placed mid-frame while locked, and enable gaps between bits, catch a window that slides or is retriggered. Changing the mismatch-limit inputs after reset, together with set pattern bits above K, catches live use of configuration or an unmasked comparison.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCK   = 1'b1
  } fs_state_e;
endpackage

// File: rtl/fsync_correlator.sv
module fsync_correlator #(
  parameter int MAX_K = 32,
  parameter int ERR_W = $clog2(MAX_K + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             bit_i,
  input  logic [MAX_K-1:0] pattern_i,
  input  logic [ERR_W-1:0] pat_len_i,
  output logic [ERR_W-1:0] mism_o
);
  logic [MAX_K-1:0] hist_q, hist_next, mask, diff;

  assign hist_next = {hist_q[MAX_K-2:0], bit_i};

  for (genvar i = 0; i < MAX_K; i++) begin : g_mask
    assign mask[i] = (pat_len_i > ERR_W'(i));
  end

  assign diff = (hist_next ^ pattern_i) & mask;

  always_comb begin
    mism_o = '0;
    for (int i = 0; i < MAX_K; i++) begin
      mism_o = mism_o + {{(ERR_W-1){1'b0}}, diff[i]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hist_q <= '0;
    else if (bit_en_i) hist_q <= hist_next;
  end
endmodule

// File: rtl/fsync_bit_counter.sv
module fsync_bit_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] frame_len_i,
  output logic             window_o
);
  logic [CNT_W-1:0] cnt_q;

  assign window_o = bit_en_i && (cnt_q == frame_len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_W'(1);
    end else if (bit_en_i) begin
      // cnt_q counts enabled bits since the last sync end
      if (reload_i || window_o) cnt_q <= CNT_W'(1);
      else                      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/fsync_strategy.sv
module fsync_strategy
  import fsync_pkg::*;
#(
  parameter int ERR_W = 6,
  parameter int VER_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             window_i,
  input  logic [ERR_W-1:0] mism_i,
  input  logic [ERR_W-1:0] search_tol_i,
  input  logic [ERR_W-1:0] lock_tol_i,
  input  logic [VER_W-1:0] verify_i,
  output logic             reload_o,
  output logic             lock_o,
  output logic             search_pulse_o,
  output logic             frame_ok_o,
  output logic             miss_o
);
  fs_state_e        state_q, state_d;
  logic [VER_W-1:0] run_q, run_d;
  logic             ok_d, miss_d;
  logic             hit_s, hit_l;

  assign hit_s = (mism_i <= search_tol_i);
  assign hit_l = (mism_i <= lock_tol_i);

  always_comb begin
    state_d  = state_q;
    run_d    = run_q;
    reload_o = 1'b0;
    ok_d     = 1'b0;
    miss_d   = 1'b0;
    if (bit_en_i) begin
      unique case (state_q)
        ST_SEARCH: begin
          if (run_q == '0) begin
            if (hit_s) begin
              reload_o = 1'b1;
              if (verify_i == '0) state_d = ST_LOCK;
              else                run_d   = VER_W'(1);
            end
          end else if (window_i) begin
            if (!hit_s) begin
              run_d = '0;
            end else if (run_q == verify_i) begin
              state_d = ST_LOCK;
              run_d   = '0;
            end else begin
              run_d = run_q + VER_W'(1);
            end
          end
        end
        ST_LOCK: begin
          if (window_i) begin
            if (hit_l) begin
              run_d = '0;
              ok_d  = 1'b1;
            end else if (run_q == verify_i) begin
              state_d = ST_SEARCH;
              run_d   = '0;
              miss_d  = 1'b1;
            end else begin
              run_d = run_q + VER_W'(1);
              ok_d  = 1'b1;
            end
          end
        end
        default: state_d = ST_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_SEARCH;
      run_q          <= '0;
      frame_ok_o     <= 1'b0;
      miss_o         <= 1'b0;
      search_pulse_o <= 1'b0;
    end else begin
      state_q        <= state_d;
      run_q          <= run_d;
      frame_ok_o     <= ok_d;
      miss_o         <= miss_d;
      search_pulse_o <= miss_d;
    end
  end

  assign lock_o = (state_q == ST_LOCK);
endmodule

// File: rtl/frame_sync_tracker.sv
module frame_sync_tracker #(
  parameter int MAX_K     = 32,
  parameter int MAX_FRAME = 2048,
  parameter int VER_W     = 3,
  localparam int ERR_W    = $clog2(MAX_K + 1),
  localparam int CNT_W    = $clog2(MAX_FRAME + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             bit_i,
  input  logic [MAX_K-1:0] pattern_i,
  input  logic [ERR_W-1:0] pat_len_i,
  input  logic [CNT_W-1:0] frame_len_i,
  input  logic [ERR_W-1:0] search_tol_i,
  input  logic [ERR_W-1:0] lock_tol_i,
  input  logic [VER_W-1:0] verify_i,
  output logic             lock_o,
  output logic             search_o,
  output logic             search_pulse_o,
  output logic             frame_ok_o,
  output logic             miss_o
);
  logic             armed_q;
  logic [MAX_K-1:0] pat_q, pat_e;
  logic [ERR_W-1:0] len_q, len_e, es_q, es_e, el_q, el_e;
  logic [CNT_W-1:0] flen_q, flen_e;
  logic [VER_W-1:0] ver_q, ver_e;
  logic [ERR_W-1:0] mism;
  logic             window, reload;

  // configuration is frozen at the first clock after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      pat_q   <= '0;
      len_q   <= '0;
      flen_q  <= '0;
      es_q    <= '0;
      el_q    <= '0;
      ver_q   <= '0;
    end else if (!armed_q) begin
      armed_q <= 1'b1;
      pat_q   <= pattern_i;
      len_q   <= pat_len_i;
      flen_q  <= frame_len_i;
      es_q    <= search_tol_i;
      el_q    <= lock_tol_i;
      ver_q   <= verify_i;
    end
  end

  assign pat_e  = armed_q ? pat_q  : pattern_i;
  assign len_e  = armed_q ? len_q  : pat_len_i;
  assign flen_e = armed_q ? flen_q : frame_len_i;
  assign es_e   = armed_q ? es_q   : search_tol_i;
  assign el_e   = armed_q ? el_q   : lock_tol_i;
  assign ver_e  = armed_q ? ver_q  : verify_i;

  fsync_correlator #(.MAX_K(MAX_K), .ERR_W(ERR_W)) i_corr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_en_i  (bit_en_i),
    .bit_i     (bit_i),
    .pattern_i (pat_e),
    .pat_len_i (len_e),
    .mism_o    (mism)
  );

  fsync_bit_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_en_i    (bit_en_i),
    .reload_i    (reload),
    .frame_len_i (flen_e),
    .window_o    (window)
  );

  fsync_strategy #(.ERR_W(ERR_W), .VER_W(VER_W)) i_strat (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .bit_en_i       (bit_en_i),
    .window_i       (window),
    .mism_i         (mism),
    .search_tol_i   (es_e),
    .lock_tol_i     (el_e),
    .verify_i       (ver_e),
    .reload_o       (reload),
    .lock_o         (lock_o),
    .search_pulse_o (search_pulse_o),
    .frame_ok_o     (frame_ok_o),
    .miss_o         (miss_o)
  );

  assign search_o = ~lock_o;
endmodule

// File: rtl/fsync_checker.sv
module fsync_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic lock_o,
  input logic search_o,
  input logic search_pulse_o,
  input logic frame_ok_o,
  input logic miss_o
);
  // R1
  mode_levels_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    search_o != lock_o);
  // R8
  loss_pulse_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (search_pulse_o && !lock_o));
  // R8
  lock_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> miss_o);
  // R7
  frame_ok_in_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ok_o |-> lock_o);
  // R7
  frame_ok_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ok_o |=> !frame_ok_o);
  // R9
  pulse_needs_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_ok_o || miss_o) |-> $past(bit_en_i));
  // R7
  lock_entry_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> (!frame_ok_o && !miss_o));
endmodule

bind frame_sync_tracker fsync_checker i_fsync_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .bit_en_i       (bit_en_i),
  .lock_o         (lock_o),
  .search_o       (search_o),
  .search_pulse_o (search_pulse_o),
  .frame_ok_o     (frame_ok_o),
  .miss_o         (miss_o)
);

// File: tb/test_frame_sync_tracker.sv
`timescale 1ns/1ps
module test_frame_sync_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        bit_in = 1'b0;
  logic [31:0] pattern = '0;
  logic [5:0]  pat_len = '0;
  logic [11:0] frame_len = '0;
  logic [5:0]  s_tol = '0;
  logic [5:0]  l_tol = '0;
  logic [2:0]  verify = '0;
  logic lock_o, search_o, search_pulse_o, frame_ok_o, miss_o;

  always #2 clk = ~clk;

  frame_sync_tracker i_frame_sync_tracker (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .bit_i(bit_in),
    .pattern_i(pattern), .pat_len_i(pat_len), .frame_len_i(frame_len),
    .search_tol_i(s_tol), .lock_tol_i(l_tol), .verify_i(verify),
    .lock_o(lock_o), .search_o(search_o), .search_pulse_o(search_pulse_o),
    .frame_ok_o(frame_ok_o), .miss_o(miss_o)
  );

  int    checks = 0, errors = 0, ok_seen = 0;
  string cur_req = "R1";
  int    seed = 7;
  bit    gap_mode = 0;

  // behavioural reference
  bit    m_armed, m_lock, e_ok, e_miss, e_srch;
  int    m_run, m_pos;
  bit    hist[$];
  int    c_k, c_len, c_es, c_el, c_v;
  logic [31:0] c_pat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_armed = 0; m_lock = 0; m_run = 0; m_pos = 1;
      e_ok = 0; e_miss = 0; e_srch = 0;
      hist = {};
      for (int i = 0; i < 32; i++) hist.push_back(1'b0);
    end else begin
      if (!m_armed) begin
        m_armed = 1; c_pat = pattern; c_k = pat_len; c_len = frame_len;
        c_es = s_tol; c_el = l_tol; c_v = verify;
      end
      e_ok = 0; e_miss = 0; e_srch = 0;
      if (bit_en) begin
        int  mm;
        bit  win, reload;
        hist.push_back(bit_in);
        void'(hist.pop_front());
        mm = 0;
        for (int i = 0; i < c_k; i++) if (hist[31-i] != c_pat[i]) mm++;
        win = (m_pos == c_len);
        reload = 0;
        if (!m_lock) begin
          if (m_run == 0) begin
            if (mm <= c_es) begin
              reload = 1;
              if (c_v == 0) m_lock = 1; else m_run = 1;
            end
          end else if (win) begin
            if (mm > c_es) m_run = 0;
            else if (m_run == c_v) begin m_lock = 1; m_run = 0; end
            else m_run++;
          end
        end else if (win) begin
          if (mm <= c_el) begin m_run = 0; e_ok = 1; end
          else if (m_run == c_v) begin
            m_lock = 0; m_run = 0; e_miss = 1; e_srch = 1;
          end else begin m_run++; e_ok = 1; end
        end
        m_pos = (reload || win) ? 1 : m_pos + 1;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    if (frame_ok_o) ok_seen++;
    checks++;
    if (lock_o !== m_lock || search_o !== !m_lock || frame_ok_o !== e_ok ||
        miss_o !== e_miss || search_pulse_o !== e_srch) begin
      errors++;
      $display("FAIL %s outputs {lock,search,srch_p,ok,miss}: actual %b%b%b%b%b expected %b%b%b%b%b",
               cur_req, lock_o, search_o, search_pulse_o, frame_ok_o, miss_o,
               m_lock, !m_lock, e_srch, e_ok, e_miss);
    end
  endtask

  task automatic tick(bit en, bit b);
    @(negedge clk);
    bit_en = en; bit_in = b;
    @(posedge clk);
    #1;
    compare();
  endtask

  task automatic rnd(output bit b);
    seed = seed * 1103515245 + 12345;
    b = seed[16];
  endtask

  task automatic send_bit(bit b);
    bit r;
    rnd(r);
    if (gap_mode && r) begin
      bit junk;
      rnd(junk);
      tick(0, junk);
    end
    tick(1, b);
  endtask

  task automatic send_random(int n);
    for (int i = 0; i < n; i++) begin
      bit b;
      rnd(b);
      send_bit(b);
    end
  endtask

  // sync code with nerr leading bits flipped, then payload (fake = pattern copy)
  task automatic send_frame(int nerr, bit fake = 0);
    for (int i = c_k - 1; i >= 0; i--) begin
      bit b = c_pat[i];
      if (c_k - 1 - i < nerr) b = ~b;
      send_bit(b);
    end
    for (int i = 0; i < c_len - c_k; i++) begin
      bit b;
      if (fake && i < c_k) b = c_pat[c_k - 1 - i];
      else rnd(b);
      send_bit(b);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bit_en = 0;
    #1;
    compare();
    tick(0, 0);
    tick(0, 0);
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    // configuration A: 24-bit code, 48-bit frames, no verification
    pattern = 32'hA7B5_8E93; pat_len = 6'd24; frame_len = 12'd48;
    s_tol = 6'd2; l_tol = 6'd8; verify = 3'd0;
    cur_req = "R1";
    do_reset();
    chk("R1", "lock in reset", lock_o, 0);
    chk("R1", "search in reset", search_o, 1);
    tick(0, 0);
    chk("R1", "lock after reset", lock_o, 0);

    cur_req = "R2/R11";
    send_random(30);
    send_frame(1);
    chk("R2", "lock after 1-error code", lock_o, 1);
    chk("R11", "upper pattern bits ignored", lock_o, 1);

    cur_req = "R3/R7";
    ok_seen = 0;
    send_frame(0); send_frame(8); send_frame(8);
    chk("R3", "lock kept with lock-limit errors", lock_o, 1);
    chk("R7", "frame pulses over three frames", ok_seen, 3);

    cur_req = "R6";
    send_frame(0, 1); send_frame(0, 1);
    chk("R6", "lock with off-window pattern", lock_o, 1);

    cur_req = "R9";
    gap_mode = 1;
    send_frame(0); send_frame(3); send_frame(0);
    gap_mode = 0;
    chk("R9", "lock across enable gaps", lock_o, 1);

    cur_req = "R10";
    s_tol = 6'd20; l_tol = 6'd0;
    send_frame(5);
    chk("R10", "lock limit change ignored", lock_o, 1);

    cur_req = "R4/R8";
    send_frame(9);
    chk("R4", "lock lost on first miss", lock_o, 0);

    cur_req = "R10/R2";
    send_frame(3);
    chk("R10", "search limit change ignored", lock_o, 0);
    send_frame(2);
    chk("R2", "lock at search limit", lock_o, 1);

    // configuration B: 32-bit code, 80-bit frames, one verification step
    pattern = 32'hC3A5_96F1; pat_len = 6'd32; frame_len = 12'd80;
    s_tol = 6'd2; l_tol = 6'd9; verify = 3'd1;
    cur_req = "R1";
    do_reset();
    tick(0, 0);
    cur_req = "R5";
    send_random(40);
    send_frame(0);
    chk("R5", "no lock on single hit", lock_o, 0);
    send_frame(12);
    chk("R5", "candidate dropped", lock_o, 0);
    send_frame(0);
    send_frame(1);
    chk("R5", "lock on two hits", lock_o, 1);
    send_frame(10);
    send_frame(0);
    send_frame(10);
    chk("R5", "isolated misses keep lock", lock_o, 1);
    cur_req = "R5/R8";
    send_frame(10);
    chk("R5", "lock lost on two misses", lock_o, 0);
    send_random(20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule